// File: doc/BRIEF.md
# ADC Serial Port Model

A synthesizable model of the digital serial port of a two-input, 12-bit sampling converter. It serves as the target device in a self-checking testbench. A controller raises the convert strobe to start a conversion. It then lowers the strobe and toggles a shift clock. On the rising shift-clock edges it sends a 2-bit input configuration, and on the falling edges it receives the 12-bit result, most significant bit first.

The result is taken from two parallel 12-bit channel inputs, which stand in for the analog inputs. The value is latched at the rising edge of the strobe, using the configuration received in the previous frame. Single-ended settings pass one channel through unchanged. Differential settings give the difference of the two channels, clamped at zero.

The port models four further behaviours:
- If the strobe is still high when the conversion timer expires, the port sleeps.
- Data-in bits after the first two of a frame are ignored.
- After the 12 result bits, the output sends zeros for as long as the shift clock keeps running.
- The tri-state output is split into a data signal and an output enable.

The strobe, shift clock and data-in lines pass through a two-flop synchronizer into the system clock domain. Edges are detected on the synchronized copies.

Top module: `adc_spi_model`

## Requirements
- R1: A rising strobe edge, seen while the port is idle or transferring, starts a conversion. `busy_o` is high for exactly CONV_CYCLES system clocks. A rising strobe edge during a conversion has no effect.
- R2: If the strobe is high when the conversion ends, `sleep_o` goes high and stays high until the strobe is seen low. If the strobe is already low when the conversion ends, `sleep_o` stays low.
- R3: `sdo_oe_o` is low while a conversion runs, while the port sleeps, and whenever the strobe is high. It goes high once the strobe is low and the conversion has ended. At most one of `busy_o`, `sleep_o` and `sdo_oe_o` is high at a time.
- R4: While `sdo_oe_o` is high, `sdo_o` carries the 12-bit result most significant bit first. Bit 11 is present as soon as the output is enabled. Each falling shift-clock edge advances to the next lower bit.
- R5: From the 12th falling shift-clock edge of a frame onward, `sdo_o` is 0 for as long as the strobe stays low.
- R6: On the first two rising shift-clock edges of a frame, the port captures `sdi_i`. The first bit is the single-ended flag (1 means single-ended). The second bit is the odd-channel select. Data-in bits on later rising edges of the same frame are ignored.
- R7: A configuration received in a frame applies to the conversion started by the next rising strobe edge. After reset, the configuration is single-ended channel 0 (flag 1, select 0).
- R8: The configuration, written as {flag, select}, chooses the result as follows:
  - 2'b10 gives `ch0_i`.
  - 2'b11 gives `ch1_i`.
  - 2'b00 gives `ch0_i - ch1_i`.
  - 2'b01 gives `ch1_i - ch0_i`.
  - A differential result below zero is 0, a zero difference gives code 0, and a full-scale difference gives 4095.
- R9: After reset, `sdo_oe_o`, `busy_o` and `sleep_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Convert strobe |
| sck_i | input | 1 | Shift clock |
| sdi_i | input | 1 | Serial configuration input |
| ch0_i | input | 12 | Channel 0 sample value |
| ch1_i | input | 12 | Channel 1 sample value |
| sdo_o | output | 1 | Serial result output, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the serial result |
| busy_o | output | 1 | Conversion in progress |
| sleep_o | output | 1 | Sleep state |

## Verification
A wrong configuration register shows up one frame late. Every bit of the following result is taken from the wrong channel or with the wrong sign, so the whole word differs from the expected value as soon as it is shifted out. A shift register that fails to fill with zeros shows as ones after the 12th falling edge. A timer or state error shows within one conversion time: `busy_o` is high for the wrong number of clocks, `sleep_o` has the wrong level, or the output enable comes up while the strobe is still high.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_SLEEP,
    ST_XFER
  } port_state_e;

  typedef struct packed {
    logic single;
    logic odd;
  } mux_cfg_t;

  localparam mux_cfg_t CFG_RST = '{single: 1'b1, odd: 1'b0};
  localparam int unsigned CFG_BITS = 2;
endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        last_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        last_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[b]  = chain_q[STAGES-1];
    assign rise_o[b] = chain_q[STAGES-1] & ~last_q;
    assign fall_o[b] = ~chain_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start_i)  cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_mux_sel.sv
module adc_mux_sel
  import adc_spi_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  mux_cfg_t          cfg_i,
  input  logic [DATA_W-1:0] ch0_i,
  input  logic [DATA_W-1:0] ch1_i,
  output logic [DATA_W-1:0] code_o
);
  logic [DATA_W-1:0] pos, neg;

  always_comb begin
    pos = cfg_i.odd ? ch1_i : ch0_i;
    neg = cfg_i.odd ? ch0_i : ch1_i;
    if (cfg_i.single)  code_o = pos;
    else if (pos > neg) code_o = pos - neg;
    else                code_o = '0;  // negative or zero difference clamps
  end
endmodule

// File: rtl/adc_spi_model.sv
module adc_spi_model
  import adc_spi_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] ch0_i,
  input  logic [DATA_W-1:0] ch1_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              sleep_o
);
  localparam int unsigned IDX_CONV = 0;
  localparam int unsigned IDX_SCK  = 1;
  localparam int unsigned IDX_SDI  = 2;

  logic [2:0] lvl, rise, fall;

  adc_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdi_i, sck_i, conv_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  port_state_e state_q, state_d;
  logic        load, tmr_done;
  logic [DATA_W-1:0] code, shreg_q;
  mux_cfg_t    cfg_q;
  logic        cfg_first_q;
  logic [1:0]  cfg_cnt_q;

  assign load = rise[IDX_CONV] && (state_q == ST_IDLE || state_q == ST_XFER);

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (load),
    .run_i   (state_q == ST_CONV),
    .done_o  (tmr_done)
  );

  adc_mux_sel #(.DATA_W(DATA_W)) i_mux (
    .cfg_i  (cfg_q),
    .ch0_i  (ch0_i),
    .ch1_i  (ch1_i),
    .code_o (code)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load) state_d = ST_CONV;
      ST_CONV:  if (tmr_done) state_d = lvl[IDX_CONV] ? ST_SLEEP : ST_XFER;
      ST_SLEEP: if (!lvl[IDX_CONV]) state_d = ST_XFER;
      ST_XFER:  if (load) state_d = ST_CONV;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // result shifts left on falling shift-clock edges, filling with zeros
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      shreg_q <= '0;
    else if (load)
      shreg_q <= code;
    else if (state_q == ST_XFER && fall[IDX_SCK])
      shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
  end

  // configuration: first two rising edges of a frame only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= CFG_RST;
      cfg_first_q <= 1'b0;
      cfg_cnt_q   <= '0;
    end else if (load) begin
      cfg_cnt_q <= '0;
    end else if (state_q == ST_XFER && rise[IDX_SCK] && cfg_cnt_q < 2'(CFG_BITS)) begin
      cfg_cnt_q <= cfg_cnt_q + 1'b1;
      if (cfg_cnt_q == 2'd0) cfg_first_q <= lvl[IDX_SDI];
      else                   cfg_q <= '{single: cfg_first_q, odd: lvl[IDX_SDI]};
    end
  end

  assign sdo_oe_o = (state_q == ST_XFER);
  assign sdo_o    = sdo_oe_o & shreg_q[DATA_W-1];
  assign busy_o   = (state_q == ST_CONV);
  assign sleep_o  = (state_q == ST_SLEEP);
endmodule

// File: rtl/adc_spi_model_chk.sv
module adc_spi_model_chk #(
  parameter int unsigned CONV_CYCLES = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sdo_oe_o,
  input logic busy_o,
  input logic sleep_o
);
  localparam int unsigned BW = $clog2(CONV_CYCLES + 2) + 1;
  logic [BW-1:0] busy_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 1'b1;
    else             busy_run_q <= '0;
  end

  // R1
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_run_q < BW'(CONV_CYCLES));

  // R1
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (sdo_oe_o || sleep_o));

  // R2
  sleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> sdo_oe_o);

  // R3
  excl_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, sleep_o, sdo_oe_o}));
endmodule

bind adc_spi_model adc_spi_model_chk #(.CONV_CYCLES(CONV_CYCLES)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sdo_oe_o (sdo_oe_o),
  .busy_o   (busy_o),
  .sleep_o  (sleep_o)
);

// File: tb/test_adc_spi_model.sv
module test_adc_spi_model;
  localparam int CONV_CYCLES = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic conv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [11:0] ch0 = '0, ch1 = '0;
  logic sdo, sdo_oe, busy, sleep;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_spi_model #(.CONV_CYCLES(CONV_CYCLES)) i_adc_spi_model (
    .clk_i(clk), .rst_ni(rst_ni), .conv_i(conv), .sck_i(sck), .sdi_i(sdi),
    .ch0_i(ch0), .ch1_i(ch1), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .busy_o(busy), .sleep_o(sleep));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input logic [1:0] c, input int a, input int b);
    int p = c[0] ? b : a;
    int n = c[0] ? a : b;
    if (c[1]) return p;
    return (p > n) ? p - n : 0;
  endfunction

  logic [1:0] prev_cfg = 2'b10;  // R7 reset default

  task automatic frame(input logic [1:0] cfg, input int a, input int b, input bit hold);
    logic [11:0] got = '0;
    int bcnt = 0, nz = 0;
    @(negedge clk); ch0 = 12'(a); ch1 = 12'(b); conv = 1'b1;
    if (hold) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy) bcnt++;
      end
      chk("R1 busy length", bcnt, CONV_CYCLES);
      chk("R2 sleep while strobe high", sleep, 1);
      chk("R3 oe low while strobe high", sdo_oe, 0);
      conv = 1'b0;
      repeat (6) @(negedge clk);
      chk("R2 sleep left on strobe low", sleep, 0);
    end else begin
      repeat (4) @(negedge clk);
      chk("R3 oe low during conversion", sdo_oe, 0);
      conv = 1'b0;
      repeat (40) @(negedge clk);
      chk("R2 no sleep with strobe low", sleep, 0);
    end
    chk("R3 oe high in transfer", sdo_oe, 1);
    got[11] = sdo;
    for (int k = 1; k <= 16; k++) begin
      sdi = (k == 1) ? cfg[1] : (k == 2) ? cfg[0] : ~cfg[(k + 1) % 2];
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
      repeat (6) @(negedge clk);
      if (k <= 11) got[11-k] = sdo;
      else if (sdo !== 1'b0) nz++;
    end
    chk("R4 R8 R7 R6 result word", int'(got), model(prev_cfg, a, b));
    chk("R5 zero padding", nz, 0);
    prev_cfg = cfg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 oe after reset", sdo_oe, 0);
    chk("R9 busy after reset", busy, 0);
    chk("R9 sleep after reset", sleep, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 oe idle", sdo_oe, 0);
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 4; c++) begin
        int a, b;
        case (p)
          0: begin a = 0;    b = 0;    end
          1: begin a = 4095; b = 0;    end
          2: begin a = 0;    b = 4095; end
          3: begin a = 1234; b = 1234; end
          4: begin a = 4095; b = 4095; end
          default: begin a = (p * 997 + 311 + c * 77) % 4096; b = (p * 2011 + 57) % 4096; end
        endcase
        frame(2'(c), a, b, ((p + c) % 2) == 0);
      end
    end
    frame(2'b10, 100, 200, 1'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule